// File: doc/BRIEF.md
# Decade ring counter with seven-segment decode

This block is a single decimal digit. The count lives in a five-bit twisted-ring (Johnson) register that walks through ten legal codes, one for each of 0 to 9. Each code is decoded straight to seven active-high segment outputs, so no binary count stage sits in between. A carry output makes one full square-wave period for every ten counts, so its rising edge can clock the next digit of a chain.

The two count inputs (`cnt_clk` and `cnt_inhibit`) are slow external levels. Each passes through a two-flop synchronizer on the system clock. An edge detector then turns the synchronized levels into a single-cycle step request, so the ring advances at most once per system clock. A rising `cnt_clk` counts while `cnt_inhibit` is low. A falling `cnt_inhibit` counts while `cnt_clk` is high, which lets the inhibit pin serve as a falling-edge count input.

The `clear` input returns the ring to zero and holds it there. The ripple-blank input (`rbl_in_n`, active low) and the ripple-blank output (`rbl_out_n`) suppress leading or trailing zeros across a row of digits. The lamp-test input lights every segment.

The ring is a state machine with ten named states, DIG0 to DIG9:

| State | Code (bit 4 to bit 0) |
|-------|-----------------------|
| DIG0 | 00000 |
| DIG1 | 00001 |
| DIG2 | 00011 |
| DIG3 | 00111 |
| DIG4 | 01111 |
| DIG5 | 11111 |
| DIG6 | 11110 |
| DIG7 | 11100 |
| DIG8 | 11000 |
| DIG9 | 10000 |

The transitions are as follows:

- A step moves DIGn to DIG(n+1), and DIG9 wraps to DIG0.
- With no step, the ring stays in its current state.
- `clear` moves any state to DIG0.
- Any code outside the table is illegal. On the next step it goes to DIG0.

Top module: `decade_ring_display`

## Requirements
- R1: While `rst_n` is low the ring is in DIG0. After release, with `rbl_in_n` high and `lamp_tst` low, the outputs are `seg` = 7'h3F, `carry` = 1 and `rbl_out_n` = 1.
- R2: While `clear` is high, the ring enters DIG0 at the next system clock edge and stays there. Count edges that arrive during `clear` have no effect. After `clear` falls, the next count edge gives digit 1.
- R3: Each rising edge of `cnt_clk` while `cnt_inhibit` is low advances the digit by one, modulo 10. The segment outputs show the new digit three system clocks after the input edge.
- R4: While `cnt_inhibit` is high, rising and falling edges of `cnt_clk` leave the digit unchanged.
- R5: A falling edge of `cnt_inhibit` while `cnt_clk` is high advances the digit by one. A falling edge of `cnt_inhibit` while `cnt_clk` is low does not.
- R6: `carry` is 1 for digits 0 to 4 and 0 for digits 5 to 9. Over 25 counts from zero it rises exactly twice, each time on the 9-to-0 wrap.
- R7: `seg` bit 0 is segment a and bit 6 is segment g. The patterns are: 0 = 3F, 1 = 06, 2 = 5B, 3 = 4F, 4 = 66, 5 = 6D, 6 = 7D, 7 = 07, 8 = 7F, 9 = 6F (hex).
- R8: While `lamp_tst` is high, `seg` = 7'h7F for every digit and every `rbl_in_n` value.
- R9: When `rbl_in_n` is low at digit 0, `seg` = 0 (unless `lamp_tst` is high) and `rbl_out_n` = 0. In every other case, `rbl_out_n` = 1 and `seg` shows the digit.
- R10: Lamp test wins over blanking. With `rbl_in_n` low, digit 0 and `lamp_tst` high, `seg` = 7'h7F and `rbl_out_n` stays 0.
- R11: The ring only ever holds one of the ten legal codes. Any illegal code steps to DIG0. With `lamp_tst` low and blanking inactive, `seg` therefore always shows one of the ten digit patterns.
- R12: A rising `cnt_clk` and a falling `cnt_inhibit` that reach the block together produce exactly one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| cnt_clk | input | 1 | Count clock (asynchronous level) |
| cnt_inhibit | input | 1 | Count inhibit, also a falling-edge count input |
| clear | input | 1 | Counter clear, active high |
| rbl_in_n | input | 1 | Ripple-blank enable in, active low |
| lamp_tst | input | 1 | Lamp test, lights all segments |
| seg | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| carry | output | 1 | Divide-by-ten carry |
| rbl_out_n | output | 1 | Ripple-blank out, active low |

## Verification
The hardest case to reach from the ports is the coincidence behind R12. A rising count clock and a falling inhibit must land in the same synchronizer cycle. The bench parks `cnt_clk` low and `cnt_inhibit` high, then flips both in one assignment, so both edge detectors fire in the same system clock and the result is checked as a single step. Illegal ring codes cannot be forced from the ports. They are covered by an assertion on the state register, while the bench confirms that every digit it sees decodes to a legal pattern.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int RING_W = 5;
    localparam int SEG_W  = 7;

    typedef enum logic [RING_W-1:0] {
        DIG0 = 5'b00000,
        DIG1 = 5'b00001,
        DIG2 = 5'b00011,
        DIG3 = 5'b00111,
        DIG4 = 5'b01111,
        DIG5 = 5'b11111,
        DIG6 = 5'b11110,
        DIG7 = 5'b11100,
        DIG8 = 5'b11000,
        DIG9 = 5'b10000
    } ring_t;

    localparam logic [SEG_W-1:0] SEG_ALL = 7'h7F;

    function automatic ring_t ring_succ(input ring_t s);
        ring_t n;
        unique case (s)
            DIG0:    n = DIG1;
            DIG1:    n = DIG2;
            DIG2:    n = DIG3;
            DIG3:    n = DIG4;
            DIG4:    n = DIG5;
            DIG5:    n = DIG6;
            DIG6:    n = DIG7;
            DIG7:    n = DIG8;
            DIG8:    n = DIG9;
            DIG9:    n = DIG0;
            default: n = DIG0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    assign level = chain_q[TOP];
    assign rise  = chain_q[TOP] & ~prev_q;
    assign fall  = ~chain_q[TOP] & prev_q;

endmodule

// File: rtl/johnson_ring.sv
module johnson_ring
    import decade_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  step,
    output ring_t state
);
    ring_t state_q;
    ring_t next_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= DIG0;
        else if (clear) state_q <= DIG0;
        else            state_q <= next_s;
    end

    always_comb begin
        next_s = state_q;
        if (step) begin
            unique case (state_q)
                DIG0:    next_s = DIG1;
                DIG1:    next_s = DIG2;
                DIG2:    next_s = DIG3;
                DIG3:    next_s = DIG4;
                DIG4:    next_s = DIG5;
                DIG5:    next_s = DIG6;
                DIG6:    next_s = DIG7;
                DIG7:    next_s = DIG8;
                DIG8:    next_s = DIG9;
                DIG9:    next_s = DIG0;
                default: next_s = DIG0;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import decade_pkg::*;
(
    input  ring_t            state,
    input  logic             rbl_in_n,
    input  logic             lamp_tst,
    output logic [SEG_W-1:0] seg,
    output logic             carry,
    output logic             rbl_out_n
);
    logic [SEG_W-1:0] pattern;
    logic             blank;

    always_comb begin
        unique case (state)
            DIG0:    pattern = 7'h3F;
            DIG1:    pattern = 7'h06;
            DIG2:    pattern = 7'h5B;
            DIG3:    pattern = 7'h4F;
            DIG4:    pattern = 7'h66;
            DIG5:    pattern = 7'h6D;
            DIG6:    pattern = 7'h7D;
            DIG7:    pattern = 7'h07;
            DIG8:    pattern = 7'h7F;
            DIG9:    pattern = 7'h6F;
            default: pattern = 7'h00;
        endcase
    end

    always_comb begin
        blank     = (state == DIG0) && !rbl_in_n;
        rbl_out_n = !blank;
        carry     = !state[RING_W-1];
        if (lamp_tst)   seg = SEG_ALL;
        else if (blank) seg = '0;
        else            seg = pattern;
    end

endmodule

// File: rtl/decade_ring_display.sv
module decade_ring_display
    import decade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk,
    input  logic             cnt_inhibit,
    input  logic             clear,
    input  logic             rbl_in_n,
    input  logic             lamp_tst,
    output logic [SEG_W-1:0] seg,
    output logic             carry,
    output logic             rbl_out_n
);
    logic  ck_level, ck_rise, ck_fall;
    logic  ih_level, ih_rise, ih_fall;
    logic  step;
    ring_t ring_state;

    edge_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
        .clk(clk), .rst_n(rst_n), .din(cnt_clk),
        .level(ck_level), .rise(ck_rise), .fall(ck_fall)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_ih_sync (
        .clk(clk), .rst_n(rst_n), .din(cnt_inhibit),
        .level(ih_level), .rise(ih_rise), .fall(ih_fall)
    );

    logic unused_edges;
    assign unused_edges = ck_fall ^ ih_rise;

    assign step = (ck_rise & ~ih_level) | (ih_fall & ck_level);

    johnson_ring u_ring (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .state(ring_state)
    );

    seg_decode u_dec (
        .state(ring_state), .rbl_in_n(rbl_in_n), .lamp_tst(lamp_tst),
        .seg(seg), .carry(carry), .rbl_out_n(rbl_out_n)
    );

endmodule

// File: rtl/decade_ring_chk.sv
module decade_ring_chk
    import decade_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             rbl_in_n,
    input logic             lamp_tst,
    input ring_t            state,
    input logic [SEG_W-1:0] seg,
    input logic             rbl_out_n
);
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> state == DIG0);

    p_step_succ_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && state != $past(state)) |-> state == ring_succ($past(state)));

    p_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {DIG0, DIG1, DIG2, DIG3, DIG4, DIG5, DIG6, DIG7, DIG8, DIG9});

    p_lamp_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_tst |-> seg == SEG_ALL);

    p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIG0 && !rbl_in_n) |-> (!rbl_out_n && (lamp_tst || seg == '0)));

    p_rbo_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DIG0 || rbl_in_n) |-> rbl_out_n);

endmodule

bind decade_ring_display decade_ring_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .rbl_in_n(rbl_in_n),
    .lamp_tst(lamp_tst), .state(ring_state), .seg(seg), .rbl_out_n(rbl_out_n)
);

// File: tb/sim_decade_ring_display.sv
module sim_decade_ring_display;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, cnt_clk, cnt_inhibit, clear, rbl_in_n, lamp_tst;
    logic [6:0] seg;
    logic       carry, rbl_out_n;

    int errors = 0;
    int checks = 0;
    int exp_d  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    decade_ring_display u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_inhibit(cnt_inhibit),
        .clear(clear), .rbl_in_n(rbl_in_n), .lamp_tst(lamp_tst),
        .seg(seg), .carry(carry), .rbl_out_n(rbl_out_n)
    );

    function automatic logic [6:0] digit_pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [6:0] exp_seg(input int d, input bit rbi_n, input bit lt);
        if (lt) return 7'h7F;
        if (!rbi_n && d == 0) return 7'h00;
        return digit_pat(d);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ck();
        cnt_clk = 1'b1; wait_cyc(4);
        cnt_clk = 1'b0; wait_cyc(4);
    endtask

    task automatic chk_digit(input string tag);
        chk({tag, " seg"}, seg, exp_seg(exp_d, rbl_in_n, lamp_tst));
        chk({tag, " carry"}, carry, (exp_d < 5) ? 1 : 0);
        chk({tag, " rbo"}, rbl_out_n, (!rbl_in_n && exp_d == 0) ? 0 : 1);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int rises;
        logic last_carry;
        rst_n = 0; cnt_clk = 0; cnt_inhibit = 0; clear = 0; rbl_in_n = 1; lamp_tst = 0;
        wait_cyc(3);
        chk("R1 seg in reset", seg, 7'h3F);
        rst_n = 1;
        wait_cyc(2);
        chk_digit("R1 after reset");

        // R3 R6 R7 R11: 25 rising count edges
        rises = 0; last_carry = carry;
        for (int i = 0; i < 25; i++) begin
            pulse_ck();
            exp_d = (exp_d + 1) % 10;
            chk_digit("R3 R7 R11 count");
            if (carry && !last_carry) begin
                rises++;
                chk("R6 rise at wrap", exp_d, 0);
            end
            last_carry = carry;
        end
        chk("R6 carry rises", rises, 2);

        // R3 latency: new digit shows on the third clock, not before
        cnt_clk = 1'b1;
        wait_cyc(2);
        chk("R3 not yet", seg, digit_pat(exp_d));
        wait_cyc(1);
        exp_d = (exp_d + 1) % 10;
        chk("R3 latency", seg, digit_pat(exp_d));
        cnt_clk = 1'b0; wait_cyc(4);

        // R4: inhibit blocks count clock edges
        cnt_inhibit = 1'b1; wait_cyc(4);
        for (int i = 0; i < 3; i++) begin
            pulse_ck();
            chk_digit("R4 inhibited");
        end
        // R5: falling inhibit with clock low does nothing
        cnt_inhibit = 1'b0; wait_cyc(4);
        chk_digit("R5 fall with clk low");
        // R5: falling inhibit with clock high counts
        cnt_inhibit = 1'b1; wait_cyc(4);
        cnt_clk = 1'b1; wait_cyc(4);
        chk_digit("R4 rise under inhibit");
        for (int i = 0; i < 12; i++) begin
            cnt_inhibit = 1'b0; wait_cyc(4);
            exp_d = (exp_d + 1) % 10;
            chk_digit("R5 inhibit fall");
            cnt_inhibit = 1'b1; wait_cyc(4);
            chk_digit("R5 inhibit rise");
        end
        cnt_clk = 1'b0; wait_cyc(4);
        chk_digit("R4 clk fall under inhibit");

        // R12: coincident rising clock and falling inhibit
        for (int i = 0; i < 3; i++) begin
            cnt_clk = 1'b1; cnt_inhibit = 1'b0; wait_cyc(6);
            exp_d = (exp_d + 1) % 10;
            chk_digit("R12 coincident");
            cnt_clk = 1'b0; wait_cyc(4);
            cnt_inhibit = 1'b1; wait_cyc(4);
            chk_digit("R12 restore");
        end
        cnt_inhibit = 1'b0; wait_cyc(4);

        // R2: clear
        if (exp_d == 0) begin pulse_ck(); exp_d = 1; end
        clear = 1'b1; wait_cyc(2);
        exp_d = 0;
        chk_digit("R2 clear");
        pulse_ck(); pulse_ck();
        chk_digit("R2 clear holds");
        clear = 1'b0; wait_cyc(2);
        chk_digit("R2 after clear");
        pulse_ck(); exp_d = 1;
        chk_digit("R2 first count");

        // R8 R9 R10: blanking and lamp test sweep over all digits
        for (int d = 0; d < 10; d++) begin
            for (int rb = 0; rb < 2; rb++) begin
                for (int lt = 0; lt < 2; lt++) begin
                    rbl_in_n = rb[0]; lamp_tst = lt[0];
                    wait_cyc(1);
                    chk_digit("R8 R9 R10 sweep");
                end
            end
            rbl_in_n = 1'b1; lamp_tst = 1'b0;
            pulse_ck();
            exp_d = (exp_d + 1) % 10;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule